// File: doc/BRIEF.md
# I2C Control-Register Slave with Indirect Read Pointer

This block lets an external host reach an 8-bit-addressed control register file over a two-wire I2C bus. It oversamples SCL and SDA with the system clock and finds start and stop conditions and clock edges. It then moves whole bytes between the bus and a simple register-file port of address, write data, write strobe and read data. SDA is driven open-drain: the block only ever asks for the line to be pulled low.

A write transaction carries a register address byte and then any number of data bytes. Each data byte lands one address above the previous one. Reads are indirect. The host first writes the wanted start address as data into a reserved pointer location, D0h, and closes that transaction. A later transaction with the read bit set then streams bytes out from the pointer. The pointer advances with every byte sent and keeps its value between transactions. A strap input chooses between two slave addresses, so two of these blocks can share a bus.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block answers to the 7-bit address 100000 followed by the strap value as its last bit: write byte 80h with the strap low and 82h with the strap high. It acknowledges a matching address byte by pulling SDA low during the ninth clock.
- R2: An address byte that does not match gets no acknowledge. The rest of that transaction has no effect: no write strobe and no SDA drive until the next start.
- R3: In a write, the first byte after the address byte is the register address. Both it and every following data byte are received MSB first, and each one is acknowledged.
- R4: Each data byte produces exactly one single-cycle `reg_we` pulse, with `reg_addr` and `reg_wdata` valid during the pulse. The register address then increases by one for the next byte of the same transaction, wrapping at FFh.
- R5: A data byte addressed to D0h loads the read pointer instead of the register file and gives no strobe. Auto-increment continues past it.
- R6: After the address byte with the read bit set (81h or 83h) is acknowledged, the block sends `reg_rdata` for the pointer address MSB first. It advances the pointer after each byte and sends the next byte while the host keeps acknowledging. The pointer keeps its advanced value after the transaction.
- R7: When the host does not acknowledge a read byte, the block releases SDA and drives nothing more until a start or stop.
- R8: A start seen at any point, including mid-byte, restarts address reception with a cleared bit count. A stop returns the block to idle with SDA released.
- R9: The SDA drive only changes while the synchronised SCL is low.
- R10: After reset, SDA is released, no strobe is active, and both the write address and the read pointer are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Strap giving the last bit of the slave address |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| reg_addr | output | 8 | Register-file address (write address, or read pointer in a read) |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register-file contents at `reg_addr`, combinational |

## Verification
The bench crosses the pointer location inside one write burst. A design that strobed D0h into the register file, or that stopped incrementing after it, would corrupt the byte at D1h or misplace the pointer. It repeats a read without rewriting the pointer, so a design that restored the pointer would send old data. After a host NACK it keeps clocking and expects an all-ones byte, which catches a design that goes on sending. It also sends a wrong address, flips the strap, and aborts a byte with a repeated start. A design that acknowledged or wrote on a foreign address, decoded the strap wrongly, or kept a stale bit count would show a missing acknowledge or an unexpected strobe.

// File: rtl/i2c_rs_pkg.sv
// Shared types for the I2C register slave.
// Assumes byte-wide bus transfers and byte-wide register addresses and data.
package i2c_rs_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a start
        ST_RX,      // shifting in a byte from the host
        ST_ACK_SET, // byte complete, waiting for SCL low to drive ACK
        ST_ACK,     // ACK bit on the bus
        ST_TX,      // shifting out a read byte
        ST_TX_ACK,  // sampling the host's ACK/NACK
        ST_TX_NEXT, // host acknowledged, load next byte on SCL low
        ST_SKIP     // not addressed or NACKed: silent until start/stop
    } rs_state_e;

    typedef enum logic [1:0] {
        RX_DEV,     // slave address byte
        RX_REG,     // register address byte
        RX_DATA     // data byte
    } rx_kind_e;
endpackage

// File: rtl/i2c_rs_sync.sv
// Bus front end: brings SCL and SDA into the clock domain through a
// synchroniser chain and reports SCL edges plus start and stop conditions.
// Assumes the system clock is much faster than SCL, and that the bus idles high.
module i2c_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chains plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rs_engine.sv
// Byte engine: decodes the slave address, receives the register address and
// data bytes, and handles the pointer location and the read stream.
// Assumes reg_rdata follows reg_addr combinationally, and that the bus events
// come from i2c_rs_sync.
module i2c_rs_engine
    import i2c_rs_pkg::*;
#(
    parameter logic [5:0]        DEV_HI  = 6'b100000,
    parameter logic [BYTE_W-1:0] PTR_REG = 8'hD0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_sel,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    rs_state_e         state;
    rx_kind_e          kind;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] wr_ptr;
    logic [BYTE_W-1:0] rd_ptr;
    logic              rw;
    logic              bump;
    logic [BYTE_W-1:0] rx_byte;

    // Byte as it stands once the bit sampled now is shifted in.
    assign rx_byte  = {rx_sh[BYTE_W-2:0], sda_s};
    // Reads address the pointer, writes the running write address.
    assign reg_addr = rw ? rd_ptr : wr_ptr;

    // Protocol state machine, bit counter, pointers and register-file strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= RX_DEV;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            rw        <= 1'b0;
            bump      <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            bump   <= 1'b0;
            if (bump) wr_ptr <= wr_ptr + 1'b1;
            if (start_det) begin
                state  <= ST_RX;
                kind   <= RX_DEV;
                cnt    <= '0;
                rw     <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: if (scl_rise) begin
                        rx_sh <= rx_byte;
                        cnt   <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            cnt   <= '0;
                            state <= ST_ACK_SET;
                            case (kind)
                                RX_DEV: begin
                                    if (rx_byte[BYTE_W-1:1] != {DEV_HI, addr_sel})
                                        state <= ST_SKIP;
                                    else
                                        rw <= rx_byte[0];
                                end
                                RX_REG: wr_ptr <= rx_byte;
                                default: begin
                                    bump <= 1'b1;
                                    if (wr_ptr == PTR_REG) begin
                                        rd_ptr <= rx_byte;
                                    end else begin
                                        reg_we    <= 1'b1;
                                        reg_wdata <= rx_byte;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACK_SET: if (scl_fall) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                    end
                    ST_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        if (kind == RX_DEV && rw) begin
                            tx_sh  <= reg_rdata;
                            sda_oe <= ~reg_rdata[BYTE_W-1];
                            rd_ptr <= rd_ptr + 1'b1;
                            state  <= ST_TX;
                        end else begin
                            kind  <= (kind == RX_DEV) ? RX_REG : RX_DATA;
                            state <= ST_RX;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (cnt == LAST_BIT) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            cnt    <= cnt + 1'b1;
                            tx_sh  <= tx_sh << 1;
                            sda_oe <= ~tx_sh[BYTE_W-2];
                        end
                    end
                    ST_TX_ACK: if (scl_rise) begin
                        state <= sda_s ? ST_SKIP : ST_TX_NEXT;
                    end
                    ST_TX_NEXT: if (scl_fall) begin
                        tx_sh  <= reg_rdata;
                        sda_oe <= ~reg_rdata[BYTE_W-1];
                        rd_ptr <= rd_ptr + 1'b1;
                        state  <= ST_TX;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: the strobe lasts one cycle.
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    // R4: the address moves on by one right after a strobe.
    p_we_addr_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + 8'd1));
    // R5: the pointer location never reaches the register file.
    p_ptr_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_addr != PTR_REG));
    // R8: a stop always leaves SDA released.
    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    // R9: SDA drive changes only after SCL has gone low.
    p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));
    // R2, R7: a silent slave does not touch SDA.
    p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);
endmodule

// File: rtl/i2c_reg_slave.sv
// Top: I2C slave for an 8-bit control register file, with writes that
// auto-increment and reads through a pointer location.
// Assumes an open-drain pad outside the block: sda_oe=1 pulls SDA low.
module i2c_reg_slave #(
    parameter logic [5:0] DEV_HI      = 6'b100000,
    parameter logic [7:0] PTR_REG     = 8'hD0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_sel,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rs_engine #(.DEV_HI(DEV_HI), .PTR_REG(PTR_REG)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .addr_sel(addr_sel),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata)
    );
endmodule

// File: tb/sim_i2c_reg_slave.sv
// Bench: bus-functional host plus a register-file model. Driver tasks queue
// the expected writes, and a monitor pops and compares them on each strobe.
module sim_i2c_reg_slave;
    localparam int HQ = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m_low = 1'b0;
    logic       addr_sel = 1'b0;
    logic       sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       sda_bus;
    logic [7:0] regs [256];
    logic [7:0] exp_mem [256];
    logic [15:0] wq [$];
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;
    assign sda_bus   = ~(sda_m_low | sda_oe);
    assign reg_rdata = regs[reg_addr];

    i2c_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: every strobe must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (wq.size() == 0) begin
                check(1'b0, "R2/R5 unexpected strobe", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [15:0] it;
                it = wq.pop_front();
                check(it == {reg_addr, reg_wdata}, "R4 write addr/data", {reg_addr, reg_wdata}, it);
            end
            regs[reg_addr] = reg_wdata;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m_low = 1'b0; wt(HQ);
        scl_m = 1'b1;     wt(HQ);
        sda_m_low = 1'b1; wt(HQ);
        scl_m = 1'b0;     wt(HQ);
    endtask

    task automatic bus_stop();
        sda_m_low = 1'b1; wt(HQ);
        scl_m = 1'b1;     wt(HQ);
        sda_m_low = 1'b0; wt(HQ);
    endtask

    task automatic put_bit(input bit b);
        sda_m_low = ~b; wt(HQ);
        scl_m = 1'b1;   wt(2*HQ);
        scl_m = 1'b0;   wt(HQ);
    endtask

    task automatic get_bit(output bit b);
        sda_m_low = 1'b0; wt(HQ);
        scl_m = 1'b1;     wt(HQ);
        b = sda_bus;      wt(HQ);
        scl_m = 1'b0;     wt(HQ);
    endtask

    task automatic put_byte(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic get_byte(input bit ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(~ack);
    endtask

    // Write n bytes (base, base+11h, ...) from register ra; queue the expected strobes.
    task automatic write_burst(input logic [7:0] dev, input logic [7:0] ra, input int n,
                               input logic [7:0] base, input bit hit);
        bit ack;
        logic [7:0] a = ra;
        bus_start();
        put_byte(dev, ack);
        check(ack == hit, hit ? "R1 address acknowledged" : "R2 foreign address not acknowledged", ack, hit);
        put_byte(ra, ack);
        check(ack == hit, "R3 register address byte ack", ack, hit);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = base + 8'(i * 17);
            if (hit && a != 8'hD0) begin
                wq.push_back({a, d});
                exp_mem[a] = d;
            end
            put_byte(d, ack);
            check(ack == hit, "R3 data byte ack", ack, hit);
            a = a + 8'd1;
        end
        bus_stop();
    endtask

    // Read n bytes from the current pointer position st; optionally clock a byte after the NACK.
    task automatic read_burst(input logic [7:0] dev, input int n, input logic [7:0] st, input bit extra);
        bit ack;
        logic [7:0] v;
        bus_start();
        put_byte(dev, ack);
        check(ack, "R6 read address acknowledged", ack, 1);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, v);
            check(v == exp_mem[8'(st + i)], "R6 read data", v, exp_mem[8'(st + i)]);
        end
        if (extra) begin
            get_byte(1'b0, v);
            check(v == 8'hFF, "R7 SDA released after NACK", v, 8'hFF);
        end
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        bit ack;
        for (int i = 0; i < 256; i++) begin
            regs[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        wt(5);
        rst_n = 1'b1;
        wt(3);
        // R10: reset state at the ports.
        check(sda_oe == 1'b0, "R10 SDA released after reset", sda_oe, 0);
        check(reg_we == 1'b0, "R10 no strobe after reset", reg_we, 0);
        check(reg_addr == 8'h00, "R10 address zero after reset", reg_addr, 0);
        // R10: read pointer starts at 00h.
        read_burst(8'h81, 1, 8'h00, 1'b0);
        // R3/R4: burst write with auto-increment.
        write_burst(8'h80, 8'h10, 4, 8'hA1, 1'b1);
        // R5: set pointer, then R6 read with R7 NACK handling.
        write_burst(8'h80, 8'hD0, 1, 8'h10, 1'b1);
        read_burst(8'h81, 4, 8'h10, 1'b1);
        // R6: pointer kept its advanced value.
        read_burst(8'h81, 2, 8'h14, 1'b0);
        // R2: foreign address, payload aimed at 31h must vanish.
        write_burst(8'h84, 8'h31, 2, 8'h66, 1'b0);
        // R1: strap high moves the address to 82h.
        addr_sel = 1'b1;
        write_burst(8'h80, 8'h30, 1, 8'h77, 1'b0);
        write_burst(8'h82, 8'h30, 1, 8'h77, 1'b1);
        write_burst(8'h82, 8'hD0, 1, 8'h30, 1'b1);
        read_burst(8'h83, 2, 8'h30, 1'b0);
        // R8: repeated start in the middle of a byte.
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        put_byte(8'h82, ack);
        check(ack, "R8 address ack after mid-byte start", ack, 1);
        put_byte(8'h40, ack);
        wq.push_back({8'h40, 8'h9C});
        exp_mem[8'h40] = 8'h9C;
        put_byte(8'h9C, ack);
        check(ack, "R8 data ack after mid-byte start", ack, 1);
        bus_stop();
        check(sda_oe == 1'b0, "R8 SDA released after stop", sda_oe, 0);
        // R5: burst crossing the pointer location: CFh, D0h (pointer=40h), D1h.
        bus_start();
        put_byte(8'h82, ack);
        put_byte(8'hCF, ack);
        wq.push_back({8'hCF, 8'h11}); exp_mem[8'hCF] = 8'h11;
        put_byte(8'h11, ack);
        put_byte(8'h40, ack);
        check(ack, "R5 pointer byte acknowledged", ack, 1);
        wq.push_back({8'hD1, 8'h22}); exp_mem[8'hD1] = 8'h22;
        put_byte(8'h22, ack);
        bus_stop();
        read_burst(8'h83, 1, 8'h40, 1'b0);
        wt(10);
        check(wq.size() == 0, "R4 all expected strobes seen", wq.size(), 0);
        finish_up();
    end
endmodule